// File: doc/BRIEF.md
# Timer Event Flag and Interrupt Request Unit

This block holds the event flags of a two-channel general-purpose timer. The timer core gives it one-cycle pulses for counter overflow, channel capture or compare, commutation update and trigger edges, a level for the brake input, and a pulse for a software event-generate request. Each event sets a sticky flag. Software reads the flags through a 16-bit register and clears chosen flags by writing 0 to their bits. A write of 1 to a bit leaves that bit as it is.

A channel in capture mode also clears its flag when the core reports a read of that channel's capture data register. The unit records a second capture that arrives before the first was serviced in a per-channel recapture flag. A per-bit enable word masks the flags into one interrupt request. The recapture flags never reach the request.

Top module: `tmr_irq_status`

## Requirements
- R1: The read word places the flags as follows: bit 0 overflow, bit 1 channel 1, bit 2 channel 2, bit 5 commutation, bit 6 trigger, bit 7 brake, bit 9 channel 1 recapture, bit 10 channel 2 recapture. Bits 3, 4, 8 and 11 to 15 always read 0. The read word is combinational from the flag registers.
- R2: While reset is asserted, every flag is 0, and every flag is still 0 right after reset is released.
- R3: Every flag sets at the clock edge that samples its set condition. A bus write with bit k at 0 clears flag k at that edge. A bus write with bit k at 1 leaves flag k unchanged.
- R4: When a set condition and any clear condition hit the same flag at the same edge, the flag ends at 1.
- R5: The overflow flag sets on a counter overflow pulse. It also sets on a software event-generate pulse.
- R6: A channel flag sets on that channel's event pulse. The pulse means a capture when the channel mode input is 0, and a compare match when the mode input is 1.
- R7: With the mode input at 0 (capture), a capture-data read strobe clears that channel's flag.
- R8: With the mode input at 1 (compare), a capture-data read strobe has no effect on that channel's flag.
- R9: A recapture flag sets when its channel, with the mode input at 0, receives a capture event while its channel flag is already 1. Only a bus write of 0 clears it. A read strobe does not clear it.
- R10: The commutation flag sets on a commutation-update pulse and the trigger flag sets on a trigger-edge pulse. The brake flag sets at every edge at which the brake level is 1.
- R11: The interrupt request is 1 exactly when, for some bit in {0,1,2,5,6,7}, both the flag and the same-numbered bit of the enable word are 1. The enable bits of the recapture and reserved positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovf_evt | input | 1 | Counter overflow pulse |
| swgen_evt | input | 1 | Software event-generate pulse for overflow |
| chan_evt | input | 2 | Per-channel capture or compare pulse |
| chan_out_mode | input | 2 | Per-channel mode: 0 capture, 1 compare |
| chan_dr_rd | input | 2 | Per-channel capture data read strobe |
| hall_evt | input | 1 | Commutation update pulse |
| trig_evt | input | 1 | Trigger edge pulse |
| brake_lvl | input | 1 | Brake input at its active level |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data (0 clears) |
| irq_en | input | 16 | Per-bit interrupt enable, aligned to flag bits |
| bus_rdata | output | 16 | Register read data |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the following: reserved bits stay at 0, each set source wins its edge, a write of 0 clears and a write of 1 holds, read strobes take effect only in capture mode, recapture detection works, and the request matches the enabled flags. The bench's scenarios cover behaviour across several cycles. These are: a recapture flag that survives a later read strobe and a cleared channel flag, a brake level held through a clearing write, a mode change between a capture and a read, and long random mixes of simultaneous sets and clears, all compared against a reference model on every clock.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int REG_W    = 16;
  localparam int OVF_BIT  = 0;
  localparam int CH_BASE  = 1;
  localparam int HALL_BIT = 5;
  localparam int TRIG_BIT = 6;
  localparam int BRK_BIT  = 7;
  localparam int RC_BASE  = 9;

  // Next value of a sticky flag: a set beats any clear.
  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Bits that may reach the interrupt request.
  function automatic logic [REG_W-1:0] irq_mask(input int nch);
    logic [REG_W-1:0] m;
    m = '0;
    m[OVF_BIT]  = 1'b1;
    m[HALL_BIT] = 1'b1;
    m[TRIG_BIT] = 1'b1;
    m[BRK_BIT]  = 1'b1;
    for (int i = 0; i < nch; i++) m[CH_BASE+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  import tmr_irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= next_flag(flag_o, set_i, clr_i);
  end
endmodule

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic out_mode_i,
  input  logic dr_rd_i,
  input  logic wr_clr_flag_i,
  input  logic wr_clr_rc_i,
  output logic flag_o,
  output logic rcap_o
);
  logic cap_evt;
  logic rd_clr;
  logic rcap_set;

  assign cap_evt  = evt_i & ~out_mode_i;
  assign rd_clr   = dr_rd_i & ~out_mode_i;
  assign rcap_set = cap_evt & flag_o;

  tmr_irq_flag u_main (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i),
    .clr_i(wr_clr_flag_i | rd_clr), .flag_o(flag_o)
  );

  tmr_irq_flag u_rcap (
    .clk(clk), .rst_n(rst_n), .set_i(rcap_set),
    .clr_i(wr_clr_rc_i), .flag_o(rcap_o)
  );
endmodule

// File: rtl/tmr_irq_combine.sv
module tmr_irq_combine #(
  parameter int W = 16
) (
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  assign irq_o = |(flags_i & en_i & mask_i);
endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status #(
  parameter int NCH = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ovf_evt,
  input  logic                           swgen_evt,
  input  logic [NCH-1:0]                 chan_evt,
  input  logic [NCH-1:0]                 chan_out_mode,
  input  logic [NCH-1:0]                 chan_dr_rd,
  input  logic                           hall_evt,
  input  logic                           trig_evt,
  input  logic                           brake_lvl,
  input  logic                           bus_wr,
  input  logic [tmr_irq_pkg::REG_W-1:0]  bus_wdata,
  input  logic [tmr_irq_pkg::REG_W-1:0]  irq_en,
  output logic [tmr_irq_pkg::REG_W-1:0]  bus_rdata,
  output logic                           irq
);
  import tmr_irq_pkg::*;

  localparam logic [REG_W-1:0] IRQ_MASK = irq_mask(NCH);

  // Per-bit clear request from the bus (write of 0).
  logic [REG_W-1:0] wr_clr;
  assign wr_clr = bus_wr ? ~bus_wdata : '0;

  logic ovf_flag, hall_flag, trig_flag, brk_flag;
  logic [NCH-1:0] ch_flag, ch_rcap;

  tmr_irq_flag u_ovf (
    .clk(clk), .rst_n(rst_n), .set_i(ovf_evt | swgen_evt),
    .clr_i(wr_clr[OVF_BIT]), .flag_o(ovf_flag)
  );
  tmr_irq_flag u_hall (
    .clk(clk), .rst_n(rst_n), .set_i(hall_evt),
    .clr_i(wr_clr[HALL_BIT]), .flag_o(hall_flag)
  );
  tmr_irq_flag u_trig (
    .clk(clk), .rst_n(rst_n), .set_i(trig_evt),
    .clr_i(wr_clr[TRIG_BIT]), .flag_o(trig_flag)
  );
  tmr_irq_flag u_brk (
    .clk(clk), .rst_n(rst_n), .set_i(brake_lvl),
    .clr_i(wr_clr[BRK_BIT]), .flag_o(brk_flag)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_irq_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .evt_i(chan_evt[c]), .out_mode_i(chan_out_mode[c]), .dr_rd_i(chan_dr_rd[c]),
      .wr_clr_flag_i(wr_clr[CH_BASE+c]), .wr_clr_rc_i(wr_clr[RC_BASE+c]),
      .flag_o(ch_flag[c]), .rcap_o(ch_rcap[c])
    );
  end

  always_comb begin
    bus_rdata           = '0;
    bus_rdata[OVF_BIT]  = ovf_flag;
    bus_rdata[HALL_BIT] = hall_flag;
    bus_rdata[TRIG_BIT] = trig_flag;
    bus_rdata[BRK_BIT]  = brk_flag;
    for (int c = 0; c < NCH; c++) begin
      bus_rdata[CH_BASE+c] = ch_flag[c];
      bus_rdata[RC_BASE+c] = ch_rcap[c];
    end
  end

  tmr_irq_combine #(.W(REG_W)) u_comb (
    .flags_i(bus_rdata), .en_i(irq_en), .mask_i(IRQ_MASK), .irq_o(irq)
  );
endmodule

// File: rtl/tmr_irq_status_chk.sv
module tmr_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ovf_evt,
  input logic        swgen_evt,
  input logic [1:0]  chan_evt,
  input logic [1:0]  chan_out_mode,
  input logic [1:0]  chan_dr_rd,
  input logic        hall_evt,
  input logic        trig_evt,
  input logic        brake_lvl,
  input logic        bus_wr,
  input logic [15:0] bus_wdata,
  input logic [15:0] irq_en,
  input logic [15:0] bus_rdata,
  input logic        irq
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 16'hF918) == 16'h0000);

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt || swgen_evt) |=> bus_rdata[0]);

  // R3
  wr_zero_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wdata[0] && !ovf_evt && !swgen_evt) |=> !bus_rdata[0]);

  // R3
  wr_one_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[6] && !trig_evt) |=> $stable(bus_rdata[6]));

  // R4
  brk_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brake_lvl |=> bus_rdata[7]);

  // R6
  ch1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_evt[0] |=> bus_rdata[1]);

  // R7
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_dr_rd[0] && !chan_out_mode[0] && !chan_evt[0]) |=> !bus_rdata[1]);

  // R8
  rd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_dr_rd[1] && chan_out_mode[1] && !bus_wr && bus_rdata[2]) |=> bus_rdata[2]);

  // R9
  rcap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_evt[0] && !chan_out_mode[0] && bus_rdata[1]) |=> bus_rdata[9]);

  // R9
  rcap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[10] && !(bus_wr && !bus_wdata[10])) |=> bus_rdata[10]);

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(bus_rdata & irq_en & 16'h00E7));
endmodule

bind tmr_irq_status tmr_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .swgen_evt(swgen_evt),
  .chan_evt(chan_evt), .chan_out_mode(chan_out_mode), .chan_dr_rd(chan_dr_rd),
  .hall_evt(hall_evt), .trig_evt(trig_evt), .brake_lvl(brake_lvl),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .irq_en(irq_en),
  .bus_rdata(bus_rdata), .irq(irq)
);

// File: tb/tmr_irq_status_bench.sv
module tmr_irq_status_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovf_evt = 0, swgen_evt = 0, hall_evt = 0, trig_evt = 0, brake_lvl = 0;
  logic [1:0]  chan_evt = 0, chan_out_mode = 0, chan_dr_rd = 0;
  logic        bus_wr = 0;
  logic [15:0] bus_wdata = 0, irq_en = 0;
  logic [15:0] bus_rdata;
  logic        irq;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;
  string cur_req = "R2";
  logic [15:0] model = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_status u_tmr_irq_status (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .swgen_evt(swgen_evt),
    .chan_evt(chan_evt), .chan_out_mode(chan_out_mode), .chan_dr_rd(chan_dr_rd),
    .hall_evt(hall_evt), .trig_evt(trig_evt), .brake_lvl(brake_lvl),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .irq_en(irq_en),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: apply the behaviour of one clock edge to the model.
  task automatic model_edge();
    logic [15:0] setm, clrm;
    if (!rst_n) begin model = 16'h0; return; end
    setm = 16'h0;
    clrm = bus_wr ? ~bus_wdata : 16'h0;
    if (ovf_evt || swgen_evt) setm[0] = 1;
    if (hall_evt)  setm[5] = 1;
    if (trig_evt)  setm[6] = 1;
    if (brake_lvl) setm[7] = 1;
    for (int c = 0; c < 2; c++) begin
      if (chan_evt[c]) setm[1+c] = 1;
      if (chan_evt[c] && !chan_out_mode[c] && model[1+c]) setm[9+c] = 1;
      if (chan_dr_rd[c] && !chan_out_mode[c]) clrm[1+c] = 1;
    end
    model = ((model & ~clrm) | setm) & 16'h06E7;
  endtask

  task automatic compare_now();
    logic exp_irq;
    exp_irq = |(model & irq_en & 16'h00E7);
    check16(cur_req, bus_rdata, model);
    check16("R11", {15'h0, irq}, {15'h0, exp_irq});
    check16("R1", bus_rdata & 16'hF918, 16'h0);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_now();
    ovf_evt = 0; swgen_evt = 0; hall_evt = 0; trig_evt = 0;
    chan_evt = 0; chan_dr_rd = 0; bus_wr = 0; bus_wdata = 16'hFFFF;
  endtask

  task automatic wr(input logic [15:0] d);
    bus_wr = 1; bus_wdata = d;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    tick(); tick();
    @(negedge clk); rst_n = 1;
    compare_now();
    check16("R2", bus_rdata, 16'h0);

    // R5: overflow from both sources
    cur_req = "R5"; ovf_evt = 1; tick();
    wr(16'hFFFE); tick();
    swgen_evt = 1; tick();
    check16("R5", bus_rdata, 16'h0001);

    // R3: write 1 holds, write 0 clears
    cur_req = "R3"; wr(16'hFFFF); tick();
    check16("R3", bus_rdata, 16'h0001);
    wr(16'h0000); tick();
    check16("R3", bus_rdata, 16'h0000);

    // R4: set and clear together
    cur_req = "R4"; ovf_evt = 1; wr(16'h0000); tick();
    check16("R4", bus_rdata, 16'h0001);

    // R10: commutation, trigger, brake held through a clear
    cur_req = "R10"; hall_evt = 1; trig_evt = 1; tick();
    brake_lvl = 1; wr(16'hFF7F); tick();
    wr(16'hFF7F); tick();
    check16("R10", bus_rdata, 16'h00E1);
    brake_lvl = 0; wr(16'h0000); tick();
    check16("R10", bus_rdata, 16'h0000);

    // R6/R7: capture mode, read strobe clears
    cur_req = "R7"; chan_out_mode = 2'b00; chan_evt = 2'b01; tick();
    check16("R6", bus_rdata, 16'h0002);
    chan_dr_rd = 2'b01; tick();
    check16("R7", bus_rdata, 16'h0000);

    // R8: compare mode, read strobe ignored
    cur_req = "R8"; chan_out_mode = 2'b10; chan_evt = 2'b10; tick();
    chan_dr_rd = 2'b10; tick();
    check16("R8", bus_rdata, 16'h0004);
    chan_evt = 2'b10; tick();
    check16("R8", bus_rdata, 16'h0004);
    wr(16'hFFFB); tick();

    // R9: recapture survives read strobe and channel clear
    cur_req = "R9"; chan_out_mode = 2'b00; chan_evt = 2'b10; tick();
    chan_evt = 2'b10; tick();
    check16("R9", bus_rdata, 16'h0404);
    chan_dr_rd = 2'b10; tick();
    check16("R9", bus_rdata, 16'h0400);
    wr(16'hFBFF); tick();
    check16("R9", bus_rdata, 16'h0000);

    // R11: enables, recapture enable ignored
    cur_req = "R11"; chan_evt = 2'b01; tick(); chan_evt = 2'b01; tick();
    irq_en = 16'hFF18; #1; check16("R11", {15'h0, irq}, 16'h0);
    irq_en = 16'h0002; #1; check16("R11", {15'h0, irq}, 16'h1);
    wr(16'h0000); tick();

    // Random mix against the model
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      ovf_evt = ($urandom % 8) == 0; swgen_evt = ($urandom % 16) == 0;
      hall_evt = ($urandom % 8) == 0; trig_evt = ($urandom % 8) == 0;
      brake_lvl = ($urandom % 10) == 0;
      chan_evt = 2'($urandom); chan_dr_rd = 2'($urandom);
      chan_out_mode = 2'($urandom); irq_en = 16'($urandom);
      if (($urandom % 3) == 0) wr(16'($urandom));
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule